// File: doc/BRIEF.md
# Frame Workload Statistics Counter

This block measures how much of each frame a processor spends on its work. A prescaler turns the system clock into a one-cycle pulse every microsecond. An 8-bit run counter advances by one on each pulse. A rising edge on the frame sync input clears the counter, but only if software has read the counter since the last clear. If the processor misses its read because its work ran past the frame boundary, the count carries on into the next frame. The late read then returns 125 or more, which marks the overrun.

A second 8-bit register holds a peak value that software maintains itself. At the end of each frame, software reads the counter and the peak register, compares them, and writes back the larger value. There is no hardware update path into the peak register.

Both registers sit behind a small strobe-based port with a one-bit address and a 16-bit data bus. Read data appears one cycle after the read strobe. The frame sync input is asynchronous and passes through a two-flop synchroniser before its rising edge is detected.

Top module: `frame_load_stat`

## Requirements
- R1: After reset, the run counter reads 0, the peak register reads 0, `reg_rdata` is 0, and the read-since-clear flag is set, so the first sync edge clears the counter.
- R2: A tick lasts one cycle and occurs once every `TICK_DIV` clocks. The run counter adds exactly 1 per tick, so two counter reads taken `10*TICK_DIV` cycles apart differ by 10 when no clear or saturation falls between them.
- R3: A rising edge of `fsync_async` reaches the detector after two synchroniser flops. If the counter has been read since its last clear, the counter is 0 on the third clock edge after the input rises.
- R4: If no counter read has happened since the last clear, a sync edge leaves the counter counting. A frame left unread therefore reads 125 or more afterwards.
- R5: The run counter saturates at 255 and never wraps.
- R6: A counter read in the same cycle as a detected sync edge counts as coming before the edge. The edge clears the counter and leaves the flag cleared, so a later edge with no new read does not clear.
- R7: Bits 15:8 of `reg_rdata` are always 0.
- R8: Address 1 selects the peak register. A write stores `reg_wdata[7:0]` and a read returns it.
- R9: A write to address 0 (the run counter) has no effect on the count.
- R10: `reg_rdata` is registered. It updates on the clock edge that samples `reg_rd` high and returns the selected register's value from before that edge. Without a read it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_async | input | 1 | Asynchronous frame sync |
| reg_addr | input | 1 | 0 = run counter, 1 = peak register |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data (bits 7:0 used) |
| reg_rdata | output | 16 | Registered read data, upper byte zero |

## Verification
Read data is due one edge after the read strobe. A sync edge acts on the counter at the third edge after `fsync_async` rises: two synchroniser edges, then the edge that applies the clear. A tick affects the count on the same edge on which it is raised.

The bench drives all inputs on falling edges and samples `reg_rdata` on the following falling edge. A behavioural model steps once per rising edge with the same latencies and is compared with `reg_rdata` on every cycle. The coinciding read-and-edge case is placed by counting falling edges from the sync assertion, so the read strobe lands in the cycle where the detector sees the edge.

// File: rtl/fls_pkg.sv
package fls_pkg;
  localparam int STAT_W = 8;
  localparam int BUS_W  = 16;
  typedef logic [STAT_W-1:0] stat_t;
  localparam stat_t STAT_MAX = {STAT_W{1'b1}};

  // Add one, holding at the top value
  function automatic stat_t sat_inc(input stat_t v);
    return (v == STAT_MAX) ? v : stat_t'(v + 1'b1);
  endfunction

  // Place an 8-bit value on the bus, with the upper bits zero
  function automatic logic [BUS_W-1:0] widen(input stat_t v);
    return {{(BUS_W-STAT_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/fls_tick_gen.sv
module fls_tick_gen #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = rst_n;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/fls_sync_rise.sv
module fls_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din_async};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/fls_run_counter.sv
module fls_run_counter
  import fls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  sync_rise,
  input  logic  cnt_rd,
  output logic  clear_evt,
  output logic  rd_flag,
  output stat_t count
);
  // A read in the same cycle as the edge counts as earlier
  assign clear_evt = sync_rise & (rd_flag | cnt_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      rd_flag <= 1'b1;
    end else begin
      if (clear_evt)  count <= '0;
      else if (tick)  count <= sat_inc(count);

      if (clear_evt)   rd_flag <= 1'b0;
      else if (cnt_rd) rd_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/fls_reg_port.sv
module fls_reg_port
  import fls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  stat_t            count,
  output logic             cnt_rd,
  output stat_t            peak_q,
  output logic [BUS_W-1:0] reg_rdata
);
  assign cnt_rd = reg_rd & ~reg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr) peak_q <= reg_wdata[STAT_W-1:0];
      if (reg_rd) reg_rdata <= widen(reg_addr ? peak_q : count);
    end
  end
endmodule

// File: rtl/frame_load_stat.sv
module frame_load_stat #(
  parameter int TICK_DIV    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync_async,
  input  logic        reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  import fls_pkg::*;

  logic  tick_1us;
  logic  sync_rise;
  logic  cnt_rd;
  logic  cnt_clear;
  logic  rd_flag;
  stat_t stat_cnt;
  stat_t peak_q;

  fls_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us)
  );

  fls_sync_rise #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din_async(fsync_async), .rise(sync_rise)
  );

  fls_run_counter i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .sync_rise(sync_rise),
    .cnt_rd(cnt_rd), .clear_evt(cnt_clear), .rd_flag(rd_flag),
    .count(stat_cnt)
  );

  fls_reg_port i_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .count(stat_cnt),
    .cnt_rd(cnt_rd), .peak_q(peak_q), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/fls_checker.sv
module fls_checker #(
  parameter int TICK_DIV = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        sync_rise,
  input logic        cnt_rd,
  input logic        clear_evt,
  input logic        rd_flag,
  input logic [7:0]  count,
  input logic [7:0]  peak,
  input logic        reg_addr,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata
);
  // R2: when the divider is above one, a tick is high for a single cycle
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && TICK_DIV > 1) |=> !tick);

  // R2: the count rises by at most one per cycle, and only on a tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_evt && !tick) |=> $stable(count));

  // R3: a clear leaves the counter at zero
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (count == 8'd0));

  // R4: an edge with no read since the last clear does not lower the count
  a_r4_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && !rd_flag && !cnt_rd) |=> (count >= $past(count)));

  // R5: the count holds at its top value
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'hFF && !clear_evt) |=> (count == 8'hFF));

  // R6: a read together with an edge clears, and the flag ends low
  a_r6_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && cnt_rd) |=> (count == 8'd0 && !rd_flag));

  // R6: a read with no edge sets the flag
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !sync_rise) |=> rd_flag);

  // R7: the upper byte of the read data is zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:8] == 8'd0);

  // R8: a write to the peak register is stored
  a_r8_peak_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> (peak == $past(reg_wdata[7:0])));

  // R9: a write to the counter address does not move the count
  a_r9_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !tick && !clear_evt) |=> $stable(count));

  // R10: a counter read returns the value from before the edge
  a_r10_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> (reg_rdata[7:0] == $past(count)));

  // R10: without a read strobe the read data holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd) |=> $stable(reg_rdata));
endmodule

bind frame_load_stat fls_checker #(.TICK_DIV(TICK_DIV)) i_fls_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick_1us), .sync_rise(sync_rise),
  .cnt_rd(cnt_rd), .clear_evt(cnt_clear), .rd_flag(rd_flag),
  .count(stat_cnt), .peak(peak_q), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/test_frame_load_stat.sv
`timescale 1ns/1ps
module test_frame_load_stat;
  localparam int DIV = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync_async = 1'b0;
  logic        reg_addr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #10 clk = ~clk;

  frame_load_stat #(.TICK_DIV(DIV)) i_frame_load_stat (
    .clk(clk), .rst_n(rst_n), .fsync_async(fsync_async),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Behavioural reference: the sync history is a queue of past input samples
  bit fs_hist[$];
  int m_phase, m_cnt, m_peak, m_rdata;
  bit m_flag;
  bit m_seen_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      fs_hist.delete();
      m_phase = 0; m_cnt = 0; m_peak = 0; m_rdata = 0;
      m_flag = 1; m_seen_prev = 0;
    end else begin
      bit seen;
      bit edge_now;
      bit rd_cnt;
      bit tk;
      seen     = (fs_hist.size() >= 2) ? fs_hist[fs_hist.size()-2] : 1'b0;
      edge_now = seen && !m_seen_prev;
      rd_cnt   = reg_rd && !reg_addr;
      tk       = (m_phase == DIV - 1);
      if (reg_rd) m_rdata = reg_addr ? m_peak : m_cnt;
      if (edge_now && (m_flag || rd_cnt)) begin
        m_cnt = 0; m_flag = 0;
      end else begin
        if (tk && m_cnt < 255) m_cnt++;
        if (rd_cnt) m_flag = 1;
      end
      if (reg_wr && reg_addr) m_peak = reg_wdata[7:0];
      m_phase     = tk ? 0 : m_phase + 1;
      m_seen_prev = seen;
      fs_hist.push_back(fsync_async);
      if (fs_hist.size() > 4) void'(fs_hist.pop_front());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) check("R10 per-cycle rdata", reg_rdata, m_rdata);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input bit a, output int v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wr(input bit a, input int d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_sync();
    fsync_async = 1'b1;
    idle(8);
    fsync_async = 1'b0;
    idle(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    finish_run();
  end

  initial begin
    int v, a, b;
    idle(3);
    check("R1 rdata after reset", reg_rdata, 0);
    rst_n = 1'b1;
    idle(2);
    rd(1'b0, v); check("R1 counter after reset", v, 0);
    rd(1'b1, v); check("R1 peak after reset", v, 0);

    // R8 and R7: the peak register at address 1
    wr(1'b1, 16'hFFA5);
    rd(1'b1, v); check("R8 peak readback", v, 16'h00A5);
    check("R7 upper byte zero", v >> 8, 0);

    // R9: a write to address 0 is ignored
    idle(60);
    rd(1'b0, a);
    wr(1'b0, 16'h00C8);
    rd(1'b0, v); check("R9 counter write ignored", (v == a || v == a + 1) ? 1 : 0, 1);

    // R10: read data holds without a strobe
    idle(5); check("R10 hold without read", reg_rdata, v);

    // R3: the flag is set by the reads above, so the edge clears
    idle(DIV * 3);
    pulse_sync();
    rd(1'b0, v); check("R3 cleared by edge", (v <= 1) ? 1 : 0, 1);

    // R2: 10 ticks between reads spaced 10*DIV cycles apart
    idle(DIV * 5);
    rd(1'b0, a);
    idle(DIV * 10 - 1);
    rd(1'b0, b);
    check("R2 ten ticks", b - a, 10);

    // R4: an unread frame is not cleared by the next edge
    pulse_sync();
    idle(DIV * 130);
    pulse_sync();
    rd(1'b0, v); check("R4 overrun shown", (v >= 125) ? 1 : 0, 1);

    // R5: saturation at 255
    pulse_sync();
    idle(DIV * 150);
    pulse_sync();
    idle(DIV * 150);
    rd(1'b0, v); check("R5 saturated", v, 255);

    // R6: read in the same cycle as the detected edge
    pulse_sync();
    idle(DIV * 20);
    fsync_async = 1'b1;
    idle(2);
    rd(1'b0, a);
    check("R6 same-cycle read returns old count", (a >= 19) ? 1 : 0, 1);
    idle(6);
    fsync_async = 1'b0;
    rd(1'b0, v); check("R6 edge with read clears", (v <= 1) ? 1 : 0, 1);
    // That read set the flag again, so clear it with one more edge, then test no-read
    pulse_sync();
    idle(DIV * 12);
    pulse_sync();
    rd(1'b0, v); check("R6 edge without new read keeps count", (v >= 11) ? 1 : 0, 1);

    // R8: a second peak value overwrites the first
    wr(1'b1, 16'h0037);
    rd(1'b1, v); check("R8 peak overwrite", v, 16'h0037);

    idle(4);
    finish_run();
  end
endmodule